// File: doc/BRIEF.md
# Keyed Multi-Client Watchdog Supervisor

This block is a hardware watchdog that counts down a timeout window and drives the processor reset line when the window runs out. It never raises an interrupt. Firmware cannot keep it alive with one store. Every software client enabled in a build-time mask must first pulse its own check-in bit during the current window. Firmware must then write a two-value key to the key register in order. Only that combination restarts the window. A wrong key value, or a key that arrives out of order, is treated as a fault and resets the processor at once.

Whenever the block fires a reset, it also sets a safe-state output and a sticky "unexpected reset" indicator. The reset pulse does not clear these two outputs. They stay set until firmware writes a clear code after the pulse, or until power-on reset. Dangerous actuators therefore stay off, and developers can see that a recovery took place.

Register writes use a valid/ready port. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole reset pulse, so nothing transfers while reset is asserted. A source may hold `wr_valid` high across that time, and the write transfers once ready returns. The check-in vector, the reset and the status pins are plain levels.

Top module: `kw_supervisor`

## Requirements
- R1: While `rst_n` is low and after its release, `cpu_rst_o`, `safe_o` and `unexp_rst_o` are low and `wr_ready` is high.
- R2: With no accepted service, `cpu_rst_o` rises on exactly the TIMEOUT_CYCLES-th clock edge after power-on release or after the edge that ends a reset pulse.
- R3: A reset pulse lasts max(RST_PULSE, 64) cycles and is then released. `wr_ready` is low for the whole pulse, and a write offered during the pulse, including a clear code, has no effect.
- R4: A service is 0x5A written to address 0, followed by 0xA5 written to address 0 on any of the next 16 clock edges. If it is accepted, the next timeout falls TIMEOUT_CYCLES edges after the edge that takes the 0xA5.
- R5: A write to address 0 that carries the wrong value is a fault, and `cpu_rst_o` rises on the edge that takes that write. The expected value is 0x5A when no sequence is open and 0xA5 when one is open. This covers a lone 0xA5, a repeated 0x5A, any other byte, and a 0xA5 that arrives 17 or more edges after the 0x5A.
- R6: Bit i of `alive_i` is latched when it is high at a clock edge. A completed key sequence is accepted only if every bit set in CLIENT_MASK was latched on an earlier edge. Otherwise the sequence is dropped with no restart and no fault. Bits outside the mask are not required.
- R7: The latched check-ins are cleared by an accepted service and by a reset pulse, so each window needs fresh check-ins.
- R8: `safe_o` and `unexp_rst_o` rise on the same edge as `cpu_rst_o`. Both stay high through the pulse and after it.
- R9: Writing 0xC3 to address 1 while `wr_ready` is high clears `safe_o` and `unexp_rst_o` on that edge. Any other value written to address 1 is ignored.
- R10: If no write follows an open 0x5A within 16 edges, the sequence closes with no fault, and a fresh 0x5A/0xA5 pair can still service the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Write accepted this edge; low during a reset pulse |
| wr_addr | input | ADDR_W | Register address: 0 key, 1 clear |
| wr_data | input | 8 | Write value |
| alive_i | input | N_CLIENTS | Per-client check-in pulses |
| cpu_rst_o | output | 1 | Processor reset request, active high |
| safe_o | output | 1 | Safe-state hold for actuators |
| unexp_rst_o | output | 1 | Sticky unexpected-reset indicator |

## Verification
Each result has a fixed due cycle. A fault reset, a clear and the status rise all appear on the same edge that takes the triggering write. A timeout appears exactly TIMEOUT_CYCLES edges after its reference edge, and the pulse falls exactly max(RST_PULSE, 64) edges after it rose. The bench drives inputs on falling edges and counts rising edges from power-on release. For each timing check it samples one cycle before and at the due edge, so an early or late event shows as a mismatch rather than being absorbed by a loose wait.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam logic [7:0] KEY_ARM    = 8'h5A;
  localparam logic [7:0] KEY_FIRE   = 8'hA5;
  localparam logic [7:0] CLEAR_CODE = 8'hC3;
  localparam int unsigned MIN_PULSE = 64;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic fire;
    logic fault;
  } seq_result_t;
endpackage

// File: rtl/kw_client_tracker.sv
module kw_client_tracker #(
  parameter int unsigned N_CLIENTS = 4,
  parameter logic [N_CLIENTS-1:0] CLIENT_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CLIENTS-1:0] alive_i,
  input  logic                 flush_i,
  output logic                 all_in_o
);
  logic [N_CLIENTS-1:0] seen_q;
  logic [N_CLIENTS-1:0] satisfied;

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_client
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q[g] <= 1'b0;
      else if (flush_i) seen_q[g] <= 1'b0;
      else if (alive_i[g]) seen_q[g] <= 1'b1;
    end
    assign satisfied[g] = seen_q[g] | ~CLIENT_MASK[g];
  end

  assign all_in_o = &satisfied;
endmodule

// File: rtl/kw_key_seq.sv
module kw_key_seq
  import kw_pkg::*;
#(
  parameter int unsigned KEY_WINDOW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_i,
  input  logic        key_wr_i,
  input  logic [7:0]  key_data_i,
  output seq_result_t result_o
);
  localparam int unsigned KW = $clog2(KEY_WINDOW + 1);
  localparam logic [KW-1:0] WIN_LOAD = KW'(KEY_WINDOW - 1);

  seq_state_e    state_q, state_d;
  logic [KW-1:0] win_q, win_d;

  always_comb begin
    state_d        = state_q;
    win_d          = win_q;
    result_o.fire  = 1'b0;
    result_o.fault = 1'b0;
    if (hold_i) begin
      state_d = SEQ_IDLE;
      win_d   = '0;
    end else if (key_wr_i) begin
      case (state_q)
        SEQ_IDLE: begin
          if (key_data_i == KEY_ARM) begin
            state_d = SEQ_ARMED;
            win_d   = WIN_LOAD;
          end else begin
            result_o.fault = 1'b1;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          win_d   = '0;
          if (key_data_i == KEY_FIRE) result_o.fire  = 1'b1;
          else                        result_o.fault = 1'b1;
        end
      endcase
    end else if (state_q == SEQ_ARMED) begin
      if (win_q == '0) state_d = SEQ_IDLE;
      else             win_d   = win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end
endmodule

// File: rtl/kw_window_timer.sv
module kw_window_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == '0) && !hold_i && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= RELOAD;
    else if (hold_i || restart_i)     cnt_q <= RELOAD;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/kw_reset_ctrl.sv
module kw_reset_ctrl
  import kw_pkg::*;
#(
  parameter int unsigned RST_PULSE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_i,
  input  logic clear_i,
  output logic active_o,
  output logic safe_o,
  output logic sticky_o
);
  localparam int unsigned EFF_PULSE = (RST_PULSE < MIN_PULSE) ? MIN_PULSE : RST_PULSE;
  localparam int unsigned PW = $clog2(EFF_PULSE + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(EFF_PULSE - 1);

  logic          active_q;
  logic [PW-1:0] left_q;
  logic          safe_q, sticky_q;
  logic          fire;

  assign fire = trigger_i && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (fire) begin
      active_q <= 1'b1;
      left_q   <= PULSE_LOAD;
    end else if (active_q) begin
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      safe_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else if (fire) begin
      safe_q   <= 1'b1;
      sticky_q <= 1'b1;
    end else if (clear_i && !active_q) begin
      safe_q   <= 1'b0;
      sticky_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign safe_o   = safe_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/kw_supervisor.sv
module kw_supervisor
  import kw_pkg::*;
#(
  parameter int unsigned N_CLIENTS      = 4,
  parameter logic [N_CLIENTS-1:0] CLIENT_MASK = '1,
  parameter int unsigned TIMEOUT_CYCLES = 60_000_000,
  parameter int unsigned RST_PULSE      = 64,
  parameter int unsigned KEY_WINDOW     = 16,
  parameter int unsigned ADDR_W         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [N_CLIENTS-1:0] alive_i,
  output logic                 cpu_rst_o,
  output logic                 safe_o,
  output logic                 unexp_rst_o
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(1);

  logic        rst_active;
  logic        xfer, key_wr, clr_wr;
  logic        all_in, service_ok, expire;
  seq_result_t seq_res;

  assign wr_ready = !rst_active;
  assign xfer     = wr_valid && wr_ready;
  assign key_wr   = xfer && (wr_addr == KEY_ADDR);
  assign clr_wr   = xfer && (wr_addr == CLR_ADDR) && (wr_data == CLEAR_CODE);

  kw_client_tracker #(
    .N_CLIENTS  (N_CLIENTS),
    .CLIENT_MASK(CLIENT_MASK)
  ) u_clients (
    .clk     (clk),
    .rst_n   (rst_n),
    .alive_i (alive_i),
    .flush_i (service_ok || rst_active),
    .all_in_o(all_in)
  );

  kw_key_seq #(
    .KEY_WINDOW(KEY_WINDOW)
  ) u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (rst_active),
    .key_wr_i  (key_wr),
    .key_data_i(wr_data),
    .result_o  (seq_res)
  );

  assign service_ok = seq_res.fire && all_in;

  kw_window_timer #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (rst_active),
    .restart_i(service_ok),
    .expire_o (expire)
  );

  kw_reset_ctrl #(
    .RST_PULSE(RST_PULSE)
  ) u_rstctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger_i(expire || seq_res.fault),
    .clear_i  (clr_wr),
    .active_o (rst_active),
    .safe_o   (safe_o),
    .sticky_o (unexp_rst_o)
  );

  assign cpu_rst_o = rst_active;
endmodule

// File: rtl/kw_supervisor_chk.sv
module kw_supervisor_chk
  import kw_pkg::*;
#(
  parameter int unsigned RST_PULSE = 64,
  parameter int unsigned ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              cpu_rst_o,
  input logic              safe_o,
  input logic              unexp_rst_o
);
  localparam int unsigned EFF_PULSE = (RST_PULSE < MIN_PULSE) ? MIN_PULSE : RST_PULSE;

  int unsigned hi_cnt;
  logic        clr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= 0;
    else if (cpu_rst_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  assign clr_seen = wr_valid && wr_ready && (wr_addr == ADDR_W'(1)) && (wr_data == CLEAR_CODE);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_o) |-> hi_cnt == EFF_PULSE);

  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |-> hi_cnt < EFF_PULSE);

  assert_ready_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |-> !wr_ready);

  assert_safe_with_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |-> safe_o && unexp_rst_o);

  assert_safe_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_o) |-> $past(clr_seen));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unexp_rst_o) |-> $past(clr_seen));
endmodule

bind kw_supervisor kw_supervisor_chk #(
  .RST_PULSE(RST_PULSE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .cpu_rst_o  (cpu_rst_o),
  .safe_o     (safe_o),
  .unexp_rst_o(unexp_rst_o)
);

// File: tb/kw_supervisor_tb.sv
`timescale 1ns/1ps
module kw_supervisor_tb;
  localparam int T     = 200;
  localparam int PULSE = 64;
  localparam logic [3:0] MASK = 4'b1011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] alive = '0;
  logic       cpu_rst, safe, unexp;

  int cyc = 0;
  int c0 = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kw_supervisor #(
    .N_CLIENTS(4), .CLIENT_MASK(MASK), .TIMEOUT_CYCLES(T),
    .RST_PULSE(PULSE), .KEY_WINDOW(16), .ADDR_W(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .alive_i(alive),
    .cpu_rst_o(cpu_rst), .safe_o(safe), .unexp_rst_o(unexp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; alive = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, output int e);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    e = cyc;
  endtask

  task automatic ping(input logic [3:0] m);
    alive = m;
    @(negedge clk);
    alive = '0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic expect_rst_at(input int e, input string req);
    wait_to(e - 1);
    chk(req, "reset one cycle before due", cpu_rst, 0);
    wait_to(e);
    chk(req, "reset at due edge", cpu_rst, 1);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "cpu_rst in reset", cpu_rst, 0);
    chk("R1", "safe in reset", safe, 0);
    por();
    chk("R1", "cpu_rst after release", cpu_rst, 0);
    chk("R1", "safe after release", safe, 0);
    chk("R1", "indicator after release", unexp, 0);
    chk("R1", "ready after release", wr_ready, 1);
  endtask

  task automatic t_timeout_and_pulse();
    int e;
    por();
    expect_rst_at(c0 + T, "R2");
    chk("R8", "safe with reset", safe, 1);
    chk("R8", "indicator with reset", unexp, 1);
    wait_to(c0 + T + 5);
    chk("R3", "ready low in pulse", wr_ready, 0);
    wr(4'd1, 8'hC3, e);
    wait_to(c0 + T + PULSE - 1);
    chk("R3", "reset held to last cycle", cpu_rst, 1);
    wait_to(c0 + T + PULSE);
    chk("R3", "reset released", cpu_rst, 0);
    chk("R3", "clear during pulse dropped", safe, 1);
    chk("R8", "indicator after pulse", unexp, 1);
    expect_rst_at(c0 + T + PULSE + T, "R2");
  endtask

  task automatic t_clear();
    int e;
    por();
    wait_to(c0 + T + PULSE + 2);
    wr(4'd1, 8'h44, e);
    chk("R9", "wrong clear code keeps safe", safe, 1);
    wr(4'd1, 8'hC3, e);
    chk("R9", "clear drops safe", safe, 0);
    chk("R9", "clear drops indicator", unexp, 0);
  endtask

  task automatic t_service();
    int a, s;
    por();
    ping(4'b1011);
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'hA5, s);
    chk("R4", "no reset on service", cpu_rst, 0);
    wait_to(c0 + T);
    chk("R4", "old expiry skipped", cpu_rst, 0);
    expect_rst_at(s + T, "R4");
  endtask

  task automatic t_missing_client();
    int a, s;
    por();
    ping(4'b0111);
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'hA5, s);
    chk("R6", "missing client is no fault", cpu_rst, 0);
    expect_rst_at(c0 + T, "R6");
  endtask

  task automatic t_checkins_cleared();
    int a, s1, s2;
    por();
    ping(4'b1011);
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'hA5, s1);
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'hA5, s2);
    chk("R7", "second service no fault", cpu_rst, 0);
    expect_rst_at(s1 + T, "R7");
  endtask

  task automatic t_bad_keys();
    int e, a;
    por();
    wr(4'd0, 8'h11, e);
    chk("R5", "wrong first byte resets", cpu_rst, 1);
    chk("R8", "safe on fault", safe, 1);
    por();
    ping(4'b1011);
    wr(4'd0, 8'hA5, e);
    chk("R5", "lone second key resets", cpu_rst, 1);
    por();
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'h5A, e);
    chk("R5", "repeated first key resets", cpu_rst, 1);
  endtask

  task automatic t_key_gap();
    int a, s;
    por();
    ping(4'b1011);
    wr(4'd0, 8'h5A, a);
    wait_to(a + 15);
    wr(4'd0, 8'hA5, s);
    chk("R4", "gap 16 accepted edge", s, a + 16);
    chk("R4", "gap 16 no fault", cpu_rst, 0);
    expect_rst_at(s + T, "R4");
    por();
    ping(4'b1011);
    wr(4'd0, 8'h5A, a);
    wait_to(a + 16);
    wr(4'd0, 8'hA5, s);
    chk("R5", "gap 17 faults", cpu_rst, 1);
  endtask

  task automatic t_idle_expiry();
    int a, s;
    por();
    ping(4'b1011);
    wr(4'd0, 8'h5A, a);
    wait_to(a + 20);
    chk("R10", "open key lapses quietly", cpu_rst, 0);
    wr(4'd0, 8'h5A, a);
    wr(4'd0, 8'hA5, s);
    chk("R10", "fresh pair no fault", cpu_rst, 0);
    expect_rst_at(s + T, "R10");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_timeout_and_pulse();
        t_clear();
        t_service();
        t_missing_client();
        t_checkins_cleared();
        t_bad_keys();
        t_key_gap();
        t_idle_expiry();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule